// File: doc/BRIEF.md
# Single-Wire Cascade Packet Transmitter

This block is the controller end of a one-wire link that feeds a chain of LED driver receivers. On a start request it sends one 32-bit packet per device in the chain. Each packet is an 8-bit write command followed by three grayscale bytes, and each 24-bit grayscale word is pulled from the host through a ready/valid handshake. Bits are sent most significant first. Every bit occupies a fixed period counted in clock cycles. The period opens with a narrow high pulse, and a second narrow pulse inside the same period marks a one.

Between devices the line rests low for a short end-of-sequence gap. After the final packet it rests low for a longer latch gap, so that every receiver loads its new values at the same moment. The block then raises a one-cycle completion flag and returns to idle, where the line is low. The whole frame must be sent again whenever any grayscale value changes. The device count and the bit period are inputs that the block samples when a frame starts.

Top module: `sw_cascade_tx`

## Requirements
- R1: Each packet carries 32 bits, MSB first. Bits 31..24 are the command 8'h3A, bits 23..16 are gs_data[23:16] (first channel), bits 15..8 are gs_data[15:8], and bits 7..0 are gs_data[7:0].
- R2: A bit period lasts bit_div clock cycles, numbered 0 to bit_div-1. The line is high in cycles 0 to PULSE_CYC-1. For a one it is also high in cycles floor(bit_div/4) to floor(bit_div/4)+PULSE_CYC-1, and it is low for the rest of the period. bit_div must be at least 4*(PULSE_CYC+1).
- R3: bit_div and dev_count are captured when a start is accepted. Changing either input later in the frame has no effect on that frame.
- R4: Exactly one 24-bit word is taken per device, in a cycle where gs_ready and gs_valid are both high. The line stays low while gs_ready waits for gs_valid, and the first bit period starts in the cycle after the transfer.
- R5: After every packet except the last, the line stays low for EOS_PERIODS (4) bit periods. gs_ready is then raised for the next word.
- R6: After the last packet, the line stays low for LATCH_PERIODS (10) bit periods. done is then high for exactly one cycle, and the block returns to idle.
- R7: start is ignored while busy is high, including the cycle in which done is high. A start with dev_count equal to 0 is also ignored.
- R8: During and after reset, and whenever the block is idle, line_o, gs_ready, busy and done are low.
- R9: busy goes high in the cycle after an accepted start and stays high through the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one frame |
| dev_count | input | CNT_W | Number of devices in the chain, sampled at start |
| bit_div | input | DIV_W | Bit period in clock cycles, sampled at start |
| gs_valid | input | 1 | Host offers a grayscale word |
| gs_data | input | 24 | Grayscale bytes for three channels, first channel in the top byte |
| gs_ready | output | 1 | Block accepts a word this cycle |
| line_o | output | 1 | Serial line level |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Two events can land in the same cycle. The first pair is the completion pulse and a new start request: the bench drives start exactly in the done cycle, and it passes only if no second frame begins and gs_ready stays low afterwards. The second pair is the end of an end-of-sequence gap and a host that is late with its next word: per-device stalls lengthen the fetch wait, and the bench's per-cycle line model must then show the gap extended by exactly the stall with the following packet otherwise unchanged. Mid-frame changes of start, dev_count and bit_div are applied while bits are going out, and they must leave the waveform untouched.

// File: rtl/sw_tx_pkg.sv
package sw_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BIT,
    ST_GAP,
    ST_DONE
  } tx_state_e;

  localparam logic [7:0] WRITE_CMD = 8'h3A;
  localparam int PKT_BITS = 32;
  localparam int GS_W = 24;
endpackage

// File: rtl/sw_tx_period_timer.sv
module sw_tx_period_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  output logic [DIV_W-1:0] phase,
  output logic             period_end
);
  logic [DIV_W-1:0] phase_d;

  assign period_end = run && (phase == period - DIV_W'(1));

  always_comb begin
    if (!run || period_end) phase_d = '0;
    else                    phase_d = phase + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end

  // R2: the phase never leaves the current bit period
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase < period));
endmodule

// File: rtl/sw_tx_pulse_shaper.sv
module sw_tx_pulse_shaper #(
  parameter int DIV_W     = 16,
  parameter int PULSE_CYC = 20
) (
  input  logic             active,
  input  logic             bit_val,
  input  logic [DIV_W-1:0] phase,
  input  logic [DIV_W-1:0] period,
  output logic             line
);
  localparam int EW = DIV_W + 1;
  localparam logic [EW-1:0] PW_E = EW'(PULSE_CYC);

  logic [EW-1:0] phase_e, mark_start, mark_stop;
  logic          lead_pulse, mark_pulse;

  assign phase_e    = {1'b0, phase};
  assign mark_start = {1'b0, period >> 2};
  assign mark_stop  = mark_start + PW_E;
  assign lead_pulse = phase_e < PW_E;
  assign mark_pulse = bit_val && (phase_e >= mark_start) && (phase_e < mark_stop);
  assign line       = active && (lead_pulse || mark_pulse);
endmodule

// File: rtl/sw_cascade_tx.sv
module sw_cascade_tx
  import sw_tx_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int DIV_W         = 16,
  parameter int PULSE_CYC     = 20,
  parameter int EOS_PERIODS   = 4,
  parameter int LATCH_PERIODS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dev_count,
  input  logic [DIV_W-1:0] bit_div,
  input  logic             gs_valid,
  input  logic [23:0]      gs_data,
  output logic             gs_ready,
  output logic             line_o,
  output logic             busy,
  output logic             done
);
  localparam int BIT_W = $clog2(PKT_BITS);
  localparam int PER_W = $clog2(LATCH_PERIODS + EOS_PERIODS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(PKT_BITS - 1);
  localparam logic [PER_W-1:0] EOS_LAST  = PER_W'(EOS_PERIODS - 1);
  localparam logic [PER_W-1:0] LAT_LAST  = PER_W'(LATCH_PERIODS - 1);

  tx_state_e               st_q, st_d;
  logic [PKT_BITS-1:0]     sh_q, sh_d;
  logic [BIT_W-1:0]        bit_q, bit_d;
  logic [PER_W-1:0]        per_q, per_d;
  logic [CNT_W-1:0]        dev_q, dev_d;
  logic [DIV_W-1:0]        div_q, div_d;
  logic [DIV_W-1:0]        phase;
  logic                    period_end, timer_run, last_dev;
  logic [PER_W-1:0]        gap_last;

  assign timer_run = (st_q == ST_BIT) || (st_q == ST_GAP);
  assign last_dev  = (dev_q == CNT_W'(1));
  assign gap_last  = last_dev ? LAT_LAST : EOS_LAST;

  sw_tx_period_timer #(.DIV_W(DIV_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (timer_run),
    .period     (div_q),
    .phase      (phase),
    .period_end (period_end)
  );

  sw_tx_pulse_shaper #(.DIV_W(DIV_W), .PULSE_CYC(PULSE_CYC)) u_shaper (
    .active  (st_q == ST_BIT),
    .bit_val (sh_q[PKT_BITS-1]),
    .phase   (phase),
    .period  (div_q),
    .line    (line_o)
  );

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    per_d = per_q;
    dev_d = dev_q;
    div_d = div_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start && (dev_count != '0)) begin
          div_d = bit_div;
          dev_d = dev_count;
          st_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (gs_valid) begin
          sh_d  = {WRITE_CMD, gs_data};
          bit_d = '0;
          st_d  = ST_BIT;
        end
      end
      ST_BIT: begin
        if (period_end) begin
          if (bit_q == LAST_BIT) begin
            per_d = '0;
            st_d  = ST_GAP;
          end else begin
            bit_d = bit_q + BIT_W'(1);
            sh_d  = {sh_q[PKT_BITS-2:0], 1'b0};
          end
        end
      end
      ST_GAP: begin
        if (period_end) begin
          if (per_q == gap_last) begin
            if (last_dev) begin
              st_d = ST_DONE;
            end else begin
              dev_d = dev_q - CNT_W'(1);
              st_d  = ST_FETCH;
            end
          end else begin
            per_d = per_q + PER_W'(1);
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      per_q <= '0;
      dev_q <= '0;
      div_q <= '0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      per_q <= per_d;
      dev_q <= dev_d;
      div_q <= div_d;
    end
  end

  assign gs_ready = (st_q == ST_FETCH);
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);

  // R8: the line only moves while bits are being sent
  a_r8_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_BIT) |-> !line_o);

  // R4: words are only requested inside a frame
  a_r4_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    gs_ready |-> busy);

  // R6: the completion flag lasts one cycle and follows the latch gap
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st_q) == ST_GAP));

  // R9: a frame only begins on an accepted start request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && (dev_count != '0)));

  // R3: the captured period is held for the whole frame
  a_r3_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && ($past(st_q) != ST_IDLE)) |-> $stable(div_q));

  // R1: the gap is entered only after the full packet length
  a_r1_full_packet: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_GAP) && ($past(st_q) == ST_BIT)) |-> ($past(bit_q) == LAST_BIT));
endmodule

// File: tb/sw_cascade_tx_test.sv
`timescale 1ns/1ps
module sw_cascade_tx_test;
  localparam int PW = 3;
  localparam int CW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] dev_count = '0;
  logic [DW-1:0] bit_div = '0;
  logic          gs_valid = 1'b0;
  logic [23:0]   gs_data = '0;
  logic          gs_ready, line_o, busy, done;

  int total = 0;
  int bad = 0;
  logic [23:0] words [8];
  int stalls [8];
  int fetch_idx = 0;
  int stall_left = 0;

  always #2.5 clk = ~clk;

  sw_cascade_tx #(.CNT_W(CW), .DIV_W(DW), .PULSE_CYC(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count),
    .bit_div(bit_div), .gs_valid(gs_valid), .gs_data(gs_data),
    .gs_ready(gs_ready), .line_o(line_o), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_line(int c, int div, bit b);
    return (c < PW) || (b && (c >= div / 4) && (c < div / 4 + PW));
  endfunction

  // host model: answers gs_ready after a per-device stall
  initial begin
    forever begin
      @(negedge clk);
      if (gs_valid) begin
        gs_valid = 1'b0;
        fetch_idx++;
        stall_left = (fetch_idx < 8) ? stalls[fetch_idx] : 0;
      end else if (gs_ready) begin
        if (stall_left > 0) stall_left--;
        else begin
          gs_data  = words[fetch_idx];
          gs_valid = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run_frame(int n, int div, bit perturb);
    int w, cyc, bit_bad, gap_bad, busy_bad, idle_bad, len;
    longint ba, be;
    logic [31:0] pkt;
    w = 0; cyc = 0; bit_bad = 0; gap_bad = 0; busy_bad = 0; idle_bad = 0;
    ba = 0; be = 0;
    fetch_idx  = 0;
    stall_left = stalls[0];
    dev_count  = CW'(n);
    bit_div    = DW'(div);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!line_o && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(line_o == 1'b1, "R4 first packet after fetch", line_o, 1);
    for (int d = 0; d < n; d++) begin
      pkt = {8'h3A, words[d]};
      for (int b = 31; b >= 0; b--) begin
        for (int c = 0; c < div; c++) begin
          if (line_o !== exp_line(c, div, pkt[b])) begin
            if (bit_bad == 0) begin
              ba = longint'(line_o);
              be = longint'(exp_line(c, div, pkt[b]));
            end
            bit_bad++;
          end
          if (!busy || done) busy_bad++;
          if (perturb && cyc == 40) begin
            start     = 1'b1;
            dev_count = CW'(n + 2);
            bit_div   = DW'(div + 8);
          end
          if (perturb && cyc == 41) start = 1'b0;
          cyc++;
          @(negedge clk);
        end
      end
      len = (d < n - 1) ? (4 * div + stalls[d + 1] + 1) : (10 * div);
      for (int g = 0; g < len; g++) begin
        if (line_o !== 1'b0 || done) gap_bad++;
        if (!busy) busy_bad++;
        @(negedge clk);
      end
    end
    chk(done == 1'b1, "R6 done after latch gap", done, 1);
    chk(busy == 1'b1, "R9 busy in done cycle", busy, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R6 done lasts one cycle", done, 0);
    for (int i = 0; i < 12; i++) begin
      if (busy || gs_ready || line_o) idle_bad++;
      @(negedge clk);
    end
    chk(idle_bad == 0, "R7 start in done cycle ignored", idle_bad, 0);
    if (perturb) chk(bit_bad == 0, "R3 mid-frame input change ignored", ba, be);
    chk(bit_bad == 0, "R1 R2 packet waveform", ba, be);
    chk(gap_bad == 0, "R5 R6 gap low length", gap_bad, 0);
    chk(busy_bad == 0, "R9 busy held through frame", busy_bad, 0);
    chk(fetch_idx == n, "R4 one word per device", fetch_idx, n);
  endtask

  initial begin
    int n, div;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) stalls[i] = 0;
    repeat (4) @(negedge clk);
    chk(!line_o && !gs_ready && !busy && !done, "R8 outputs low in reset",
        {line_o, gs_ready, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!line_o && !gs_ready && !busy && !done, "R8 outputs low after reset",
        {line_o, gs_ready, busy, done}, 0);

    // R7: zero device count
    dev_count = '0;
    bit_div   = DW'(20);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (busy || gs_ready || line_o) n++;
      @(negedge clk);
    end
    chk(n == 0, "R7 zero device count ignored", n, 0);

    // R2: all ones at the shortest legal period
    words[0] = 24'hFFFFFF;
    run_frame(1, 16, 1'b0);

    // R1 R5: two devices, all-zero then mixed, late second word
    words[0] = 24'h000000;
    words[1] = 24'h5AC30F;
    stalls[0] = 0; stalls[1] = 3;
    run_frame(2, 17, 1'b0);

    // R3 R4: three devices with stalls, inputs disturbed mid-frame
    words[0] = 24'h123456; words[1] = 24'h80FF01; words[2] = 24'hC0FFEE;
    stalls[0] = 2; stalls[1] = 0; stalls[2] = 5;
    run_frame(3, 24, 1'b1);

    for (int r = 0; r < 5; r++) begin
      n   = 1 + int'($urandom % 3);
      div = 16 + int'($urandom % 15);
      for (int i = 0; i < n; i++) begin
        words[i]  = 24'($urandom);
        stalls[i] = int'($urandom % 4);
      end
      run_frame(n, div, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule